// File: doc/BRIEF.md
# Receive Holding FIFO with Error Status

This block sits between the receive shift register of one UART channel and the CPU read port. It stores up to three assembled characters, each with its parity-error, framing-error and break flag. The character at the head of the queue, together with an error status, is always visible on the read side. The CPU removes the head character by pulsing a read strobe. Status outputs are continuous, so looking at them never disturbs the queue.

The incoming character stream has no back-pressure at the block edge. The shift register side signals "character complete" with a one-cycle valid strobe and "start bit seen" with a second strobe. When the queue is full, the completed character waits in an internal holding stage. It enters the queue in the same cycle that a read frees a slot. If another start bit arrives while it waits, the waiting character is lost and the sticky overrun flag is raised. An optional flow-control mode negates the request-to-send output so that the far end stops before an overrun happens. A receiver reset realigns the pointers without erasing stored words. A receiver disable drops any pending character but keeps the queue readable.

Top module: `rx_hold_fifo`

## Requirements
- R1: The queue holds DEPTH=3 characters in arrival order. `rx_ready` is 1 when at least one character is stored. `rx_full` is 1 when all three are stored. Both are updated on the clock edge that samples `chr_valid` or `rd_pop`.
- R2: With `block_mode`=0, `rd_pe`/`rd_fe`/`rd_brk` show the flags stored with the head character, and 0 when the queue is empty.
- R3: With `block_mode`=1, each status output is the OR of that flag over every character that has been at the head since the last `err_reset` pulse. `err_reset` clears this accumulation.
- R4: Only `rd_pop` removes the head. Without a pop or a reset, `rd_data` and the head flags stay unchanged while more characters arrive behind the head.
- R5: A character completed while the queue is full is held. It enters the queue on the edge of the next `rd_pop`, so `rx_full` stays 1 across that pop and the held character is read out after those already stored.
- R6: A `start_det` pulse while a character is held discards the held character and leaves the queue unchanged. It also sets `overrun`, which stays 1 until an `err_reset` pulse.
- R7: With `rts_ctl_en`=1, a `start_det` pulse while full drives `rts_n` to 1 from the next cycle. `rts_n` returns to 0 as soon as `rx_full` falls. With `rts_ctl_en`=0, `rts_n` is 0.
- R8: An `rx_reset` pulse empties the queue (`rx_ready`=0, `rx_full`=0), drops any held character and sets both pointers to slot 0. Stored data words are kept, so `rd_data` then shows the word last written to slot 0.
- R9: While `rx_enable`=0, `chr_valid` and `start_det` are ignored and any held character is dropped. Characters already stored stay readable.
- R10: `rd_pop` on an empty queue advances the read pointer and leaves `rx_ready` at 0. `rd_data` then shows the stale word at the new read position.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| rx_enable | input | 1 | Receiver enable |
| rx_reset | input | 1 | Receiver reset command pulse |
| err_reset | input | 1 | Error reset command pulse |
| block_mode | input | 1 | 1 = accumulated (block) status, 0 = per-character status |
| rts_ctl_en | input | 1 | Enables automatic RTS negation |
| start_det | input | 1 | Start bit detected strobe |
| chr_valid | input | 1 | Character complete strobe |
| chr_data | input | 8 | Assembled character |
| chr_pe | input | 1 | Parity error of the character |
| chr_fe | input | 1 | Framing error of the character |
| chr_brk | input | 1 | Break received with the character |
| rd_pop | input | 1 | CPU data read strobe, pops the head |
| rd_data | output | 8 | Head character |
| rd_pe | output | 1 | Reported parity error status |
| rd_fe | output | 1 | Reported framing error status |
| rd_brk | output | 1 | Reported break status |
| rx_ready | output | 1 | At least one character stored |
| rx_full | output | 1 | All positions stored |
| overrun | output | 1 | Sticky overrun flag |
| rts_n | output | 1 | Request to send, active low (1 = negated) |

## Verification
The bench goes after the held fourth character. A design that dropped it would clear `rx_full` on the first pop, and one that wrote it in early would overwrite the oldest entry. It checks that a start bit during the hold loses exactly one character without disturbing the queue, and that overrun survives until cleared. Block-mode accumulation is checked across pops and after the queue empties; a design that showed only the head flags would lose errors from characters already read. Receiver reset and empty reads are checked through stale data on `rd_data`, which shows whether the data words are kept and where the pointers point.

// File: rtl/rxf_pkg.sv
package rxf_pkg;
  parameter int RXF_DW = 8;

  typedef struct packed {
    logic pe;
    logic fe;
    logic brk;
  } rxf_flags_t;

  typedef struct packed {
    logic [RXF_DW-1:0] data;
    rxf_flags_t        flg;
  } rxf_entry_t;
endpackage

// File: rtl/rxf_store.sv
module rxf_store
  import rxf_pkg::*;
#(
  parameter int DEPTH = 3
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       realign,
  input  logic       wr_en,
  input  rxf_entry_t wr_ent,
  input  logic       pop,
  output rxf_entry_t head_ent,
  output logic       not_empty,
  output logic       full
);
  localparam int PW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int CW = $clog2(DEPTH + 1);
  localparam logic [PW-1:0] LAST = PW'(DEPTH - 1);
  localparam logic [CW-1:0] CMAX = CW'(DEPTH);

  rxf_entry_t    mem [DEPTH];
  logic [PW-1:0] wr_ptr, rd_ptr;
  logic [CW-1:0] count;
  logic          do_rd;

  function automatic logic [PW-1:0] step(input logic [PW-1:0] p);
    return (p == LAST) ? '0 : p + 1'b1;
  endfunction

  // A pop on an empty queue still moves the read pointer (stale read).
  assign do_rd     = pop && (count != '0);
  assign head_ent  = mem[rd_ptr];
  assign not_empty = (count != '0);
  assign full      = (count == CMAX);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wr_ptr <= '0;
      rd_ptr <= '0;
      count  <= '0;
      for (int i = 0; i < DEPTH; i++) mem[i] <= '0;
    end else if (realign) begin
      wr_ptr     <= '0;
      rd_ptr     <= '0;
      count      <= '0;
      mem[0].flg <= '0;
    end else begin
      if (wr_en) begin
        mem[wr_ptr] <= wr_ent;
        wr_ptr      <= step(wr_ptr);
      end
      if (pop) rd_ptr <= step(rd_ptr);
      case ({wr_en, do_rd})
        2'b10:   count <= count + 1'b1;
        2'b01:   count <= count - 1'b1;
        default: count <= count;
      endcase
    end
  end
endmodule

// File: rtl/rxf_hold.sv
module rxf_hold
  import rxf_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       rx_enable,
  input  logic       rx_reset,
  input  logic       err_reset,
  input  logic       rts_ctl_en,
  input  logic       start_det,
  input  logic       chr_valid,
  input  rxf_entry_t chr_ent,
  input  logic       pop,
  input  logic       full,
  output logic       wr_en,
  output rxf_entry_t wr_ent,
  output logic       overrun,
  output logic       rts_n
);
  logic       hold_vld;
  rxf_entry_t hold_ent;
  logic       rts_neg;
  logic       space, chr_ok, start_ok;

  assign space    = !full || pop;
  assign chr_ok   = chr_valid && rx_enable && !rx_reset;
  assign start_ok = start_det && rx_enable && !rx_reset;
  assign wr_en    = (hold_vld && rx_enable && !rx_reset) ? space : (chr_ok && space);
  assign wr_ent   = hold_vld ? hold_ent : chr_ent;
  assign rts_n    = rts_ctl_en && rts_neg && full;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hold_vld <= 1'b0;
      hold_ent <= '0;
      overrun  <= 1'b0;
      rts_neg  <= 1'b0;
    end else begin
      if (err_reset) overrun <= 1'b0;

      if (!rx_enable || rx_reset) begin
        hold_vld <= 1'b0;
      end else if (hold_vld) begin
        if (space) begin
          hold_vld <= chr_ok;
          hold_ent <= chr_ent;
        end else if (chr_ok) begin
          hold_ent <= chr_ent;
          overrun  <= 1'b1;
        end else if (start_ok) begin
          hold_vld <= 1'b0;
          overrun  <= 1'b1;
        end
      end else if (chr_ok && !space) begin
        hold_vld <= 1'b1;
        hold_ent <= chr_ent;
      end

      if (!full || rx_reset)                rts_neg <= 1'b0;
      else if (start_ok && rts_ctl_en)      rts_neg <= 1'b1;
    end
  end
endmodule

// File: rtl/rxf_status.sv
module rxf_status
  import rxf_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       block_mode,
  input  logic       err_reset,
  input  logic       not_empty,
  input  rxf_flags_t head_flg,
  output rxf_flags_t rep_flg
);
  rxf_flags_t live, acc;

  assign live    = not_empty ? head_flg : '0;
  assign rep_flg = block_mode ? (acc | live) : live;

  // Accumulating the head every cycle covers every entry that reaches it.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)         acc <= '0;
    else if (err_reset) acc <= '0;
    else                acc <= acc | live;
  end
endmodule

// File: rtl/rx_hold_fifo.sv
module rx_hold_fifo
  import rxf_pkg::*;
#(
  parameter int DEPTH = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              rx_enable,
  input  logic              rx_reset,
  input  logic              err_reset,
  input  logic              block_mode,
  input  logic              rts_ctl_en,
  input  logic              start_det,
  input  logic              chr_valid,
  input  logic [RXF_DW-1:0] chr_data,
  input  logic              chr_pe,
  input  logic              chr_fe,
  input  logic              chr_brk,
  input  logic              rd_pop,
  output logic [RXF_DW-1:0] rd_data,
  output logic              rd_pe,
  output logic              rd_fe,
  output logic              rd_brk,
  output logic              rx_ready,
  output logic              rx_full,
  output logic              overrun,
  output logic              rts_n
);
  rxf_entry_t chr_ent, wr_ent, head_ent;
  rxf_flags_t rep_flg;
  logic       wr_en;

  assign chr_ent = '{data: chr_data, flg: '{pe: chr_pe, fe: chr_fe, brk: chr_brk}};

  rxf_hold u_hold (
    .clk, .rst_n, .rx_enable, .rx_reset, .err_reset, .rts_ctl_en,
    .start_det, .chr_valid, .chr_ent, .pop(rd_pop), .full(rx_full),
    .wr_en, .wr_ent, .overrun, .rts_n
  );

  rxf_store #(.DEPTH(DEPTH)) u_store (
    .clk, .rst_n, .realign(rx_reset), .wr_en, .wr_ent, .pop(rd_pop),
    .head_ent, .not_empty(rx_ready), .full(rx_full)
  );

  rxf_status u_status (
    .clk, .rst_n, .block_mode, .err_reset, .not_empty(rx_ready),
    .head_flg(head_ent.flg), .rep_flg
  );

  assign rd_data = head_ent.data;
  assign rd_pe   = rep_flg.pe;
  assign rd_fe   = rep_flg.fe;
  assign rd_brk  = rep_flg.brk;
endmodule

// File: rtl/rxf_checker.sv
module rxf_checker (
  input logic       clk,
  input logic       rst_n,
  input logic       rx_enable,
  input logic       rx_reset,
  input logic       err_reset,
  input logic       block_mode,
  input logic       rts_ctl_en,
  input logic       rd_pop,
  input logic [7:0] rd_data,
  input logic       rd_pe,
  input logic       rx_ready,
  input logic       rx_full,
  input logic       overrun,
  input logic       rts_n
);
  a_r1_full_has_data: assert property (@(posedge clk) disable iff (!rst_n)
    rx_full |-> rx_ready);

  a_r3_block_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    (block_mode && rd_pe && !err_reset) |=> (!block_mode || rd_pe));

  a_r4_head_stable: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_ready && !rd_pop && !rx_reset) |=> $stable(rd_data));

  a_r6_overrun_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    (overrun && !err_reset) |=> overrun);

  a_r7_rts_only_full: assert property (@(posedge clk) disable iff (!rst_n)
    rts_n |-> (rx_full && rts_ctl_en));

  a_r8_reset_empties: assert property (@(posedge clk) disable iff (!rst_n)
    rx_reset |=> (!rx_ready && !rx_full));

  a_r9_disabled_no_fill: assert property (@(posedge clk) disable iff (!rst_n)
    (!rx_enable && !rx_ready && !rx_reset) |=> !rx_ready);
endmodule

bind rx_hold_fifo rxf_checker u_rxf_checker (
  .clk, .rst_n, .rx_enable, .rx_reset, .err_reset, .block_mode, .rts_ctl_en,
  .rd_pop, .rd_data, .rd_pe, .rx_ready, .rx_full, .overrun, .rts_n
);

// File: tb/test_rx_hold_fifo.sv
module test_rx_hold_fifo;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic rx_enable = 1'b1, rx_reset = 1'b0, err_reset = 1'b0;
  logic block_mode = 1'b0, rts_ctl_en = 1'b0;
  logic start_det = 1'b0, chr_valid = 1'b0, rd_pop = 1'b0;
  logic [7:0] chr_data = '0;
  logic chr_pe = 1'b0, chr_fe = 1'b0, chr_brk = 1'b0;
  logic [7:0] rd_data;
  logic rd_pe, rd_fe, rd_brk, rx_ready, rx_full, overrun, rts_n;
  int checks = 0, failures = 0;
  bit done = 1'b0;

  always #10 clk = ~clk;

  rx_hold_fifo i_rx_hold_fifo (
    .clk, .rst_n, .rx_enable, .rx_reset, .err_reset, .block_mode, .rts_ctl_en,
    .start_det, .chr_valid, .chr_data, .chr_pe, .chr_fe, .chr_brk, .rd_pop,
    .rd_data, .rd_pe, .rd_fe, .rd_brk, .rx_ready, .rx_full, .overrun, .rts_n
  );

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // Drive on the falling edge; one rising edge captures; next falling edge checks.
  task automatic push(input logic [7:0] d, input logic pe, input logic fe, input logic brk);
    @(negedge clk);
    chr_valid = 1'b1; chr_data = d; chr_pe = pe; chr_fe = fe; chr_brk = brk;
    @(negedge clk);
    chr_valid = 1'b0; chr_pe = 1'b0; chr_fe = 1'b0; chr_brk = 1'b0;
  endtask

  task automatic pulse_pop();
    @(negedge clk); rd_pop = 1'b1; @(negedge clk); rd_pop = 1'b0;
  endtask

  task automatic pulse_start();
    @(negedge clk); start_det = 1'b1; @(negedge clk); start_det = 1'b0;
  endtask

  task automatic pulse_rxrst();
    @(negedge clk); rx_reset = 1'b1; @(negedge clk); rx_reset = 1'b0;
  endtask

  task automatic pulse_errrst();
    @(negedge clk); err_reset = 1'b1; @(negedge clk); err_reset = 1'b0;
  endtask

  task automatic t_reset_state();
    chk("R1 reset ready", rx_ready, 0);
    chk("R1 reset full", rx_full, 0);
    chk("R6 reset overrun", overrun, 0);
    chk("R7 reset rts_n", rts_n, 0);
  endtask

  task automatic t_order_char_mode();
    pulse_rxrst();
    block_mode = 1'b0;
    push(8'hA1, 1, 0, 0);
    chk("R1 ready after one", rx_ready, 1);
    chk("R1 not full after one", rx_full, 0);
    push(8'hA2, 0, 0, 0);
    push(8'hA3, 0, 1, 0);
    chk("R1 full after three", rx_full, 1);
    chk("R4 head unchanged", rd_data, 8'hA1);
    chk("R2 head pe", rd_pe, 1);
    pulse_pop();
    chk("R1 order second", rd_data, 8'hA2);
    chk("R2 head pe clear", rd_pe, 0);
    pulse_pop();
    chk("R1 order third", rd_data, 8'hA3);
    chk("R2 head fe", rd_fe, 1);
    pulse_pop();
    chk("R1 empty ready", rx_ready, 0);
    chk("R2 empty flags", {rd_pe, rd_fe, rd_brk}, 0);
  endtask

  task automatic t_block_mode();
    pulse_rxrst();
    block_mode = 1'b1;
    pulse_errrst();
    push(8'hB1, 1, 0, 0);
    push(8'hB2, 0, 0, 1);
    chk("R3 block head only pe", {rd_pe, rd_brk}, 2'b10);
    pulse_pop();
    chk("R3 block accumulated", {rd_pe, rd_brk}, 2'b11);
    pulse_pop();
    chk("R3 block kept when empty", {rd_pe, rd_fe, rd_brk}, 3'b101);
    pulse_errrst();
    chk("R3 err_reset clears", {rd_pe, rd_fe, rd_brk}, 0);
    block_mode = 1'b0;
  endtask

  task automatic t_hold();
    pulse_rxrst();
    push(8'hC1, 0, 0, 0); push(8'hC2, 0, 0, 0); push(8'hC3, 0, 0, 0);
    push(8'hC4, 0, 0, 0);
    chk("R5 head kept while held", rd_data, 8'hC1);
    pulse_pop();
    chk("R5 full across pop", rx_full, 1);
    chk("R5 next head", rd_data, 8'hC2);
    pulse_pop(); pulse_pop();
    chk("R5 held char last", rd_data, 8'hC4);
    pulse_pop();
    chk("R5 drained", rx_ready, 0);
    chk("R6 no overrun", overrun, 0);
  endtask

  task automatic t_overrun();
    pulse_rxrst();
    push(8'hD1, 0, 0, 0); push(8'hD2, 0, 0, 0); push(8'hD3, 0, 0, 0);
    push(8'hD4, 0, 0, 0);
    pulse_start();
    chk("R6 overrun set", overrun, 1);
    chk("R6 queue untouched", rd_data, 8'hD1);
    pulse_pop();
    chk("R6 held discarded", rx_full, 0);
    pulse_pop();
    chk("R6 last is D3", rd_data, 8'hD3);
    pulse_pop();
    chk("R6 empty", rx_ready, 0);
    chk("R6 overrun sticky", overrun, 1);
    pulse_errrst();
    chk("R6 overrun cleared", overrun, 0);
  endtask

  task automatic t_rts();
    pulse_rxrst();
    rts_ctl_en = 1'b1;
    push(8'h11, 0, 0, 0); push(8'h12, 0, 0, 0);
    pulse_start();
    chk("R7 no negate below full", rts_n, 0);
    push(8'h13, 0, 0, 0);
    pulse_start();
    chk("R7 negated when full", rts_n, 1);
    pulse_pop();
    chk("R7 reasserted", rts_n, 0);
    pulse_pop(); pulse_pop();
    rts_ctl_en = 1'b0;
  endtask

  task automatic t_rx_reset();
    pulse_rxrst();
    push(8'hE1, 1, 0, 0); push(8'hE2, 0, 0, 0);
    pulse_pop();
    chk("R8 head before reset", rd_data, 8'hE2);
    pulse_rxrst();
    chk("R8 ready cleared", rx_ready, 0);
    chk("R8 data kept slot0", rd_data, 8'hE1);
    pulse_pop();
    chk("R10 empty pop ready", rx_ready, 0);
    chk("R10 stale data", rd_data, 8'hE2);
    pulse_rxrst();
    push(8'hE3, 0, 0, 0);
    chk("R8 realigned write", rd_data, 8'hE3);
    pulse_pop();
  endtask

  task automatic t_disable();
    pulse_rxrst();
    push(8'hF0, 0, 0, 0);
    rx_enable = 1'b0;
    push(8'hF1, 0, 0, 0);
    chk("R9 readable while disabled", rd_data, 8'hF0);
    pulse_pop();
    chk("R9 ignored when disabled", rx_ready, 0);
    rx_enable = 1'b1;
    push(8'hF2, 0, 0, 0); push(8'hF3, 0, 0, 0); push(8'hF4, 0, 0, 0);
    push(8'hF5, 0, 0, 0);
    rx_enable = 1'b0;
    @(negedge clk);
    rx_enable = 1'b1;
    pulse_pop(); pulse_pop(); pulse_pop();
    chk("R9 held dropped", rx_ready, 0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset_state();
    t_order_char_mode();
    t_block_mode();
    t_hold();
    t_overrun();
    t_rts();
    t_rx_reset();
    t_disable();
    done = 1'b1;
  end

  initial begin
    fork
      wait (done);
      begin
        repeat (20000) @(posedge clk);
        checks++; failures++;
        $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
      end
    join_any
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule